// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that software drives through two 16-bit registers on a simple write-strobe register bus. The control register sits at byte offset 0 and the data register at byte offset 2. Reads are combinational. The control register holds these fields:

- an enable bit;
- a completion-interrupt enable;
- a chip-select hold flag;
- a frame-size bit;
- a 2-bit device number;
- a 2-bit rate code.

Writing the data register while the block is enabled and idle starts one frame of 8 or 16 bits. The frame runs in SPI mode 0 and sends the most significant bit first. The same shift register carries the outgoing word and collects the incoming bits.

Only the addressed device's active-low chip select is driven. The serial clock comes from the system clock through a half-period count, and each count is rounded to the nearest whole number of system cycles for its nominal rate. When the hold flag is set, the chip select stays low after the frame ends, so a multi-word command can be built from several back-to-back frames. When the hold flag is clear, the chip select is released once the frame completes. Clearing the enable bit also drops a held chip select.

Once the busy flag falls, the received word can be read back from the data register. A one-cycle interrupt pulse can mark that moment.

Top module: `spi_regmaster`

## Requirements
- R1: After reset, both registers read 0x0000, all four chip selects are high (inactive), the serial clock is low and the interrupt is low.
- R2: Control register bits map as follows: bit 15 is the enable, bit 14 the interrupt enable, bit 11 the hold flag, bit 10 the frame size (0 = 8 bits, 1 = 16 bits), bits 9..8 the device number and bits 1..0 the rate code. Bit 7 reads the busy flag. Bits 13..12 and 6..2 always read 0, so writing 0xFFFF while idle reads back 0xCF03.
- R3: A data-register write with the enable set and the block idle raises busy (bit 7) on the next cycle and drives low only chip select number [9..8]. With the enable clear, the write starts nothing: busy stays 0, all chip selects stay high and the serial clock stays low.
- R4: An 8-bit frame gives exactly 8 rising serial-clock edges. The MOSI value at the rising edges equals the low byte written, MSB first. MISO is sampled at the rising edges, and the data register then reads {8'h00, received byte}.
- R5: A 16-bit frame gives exactly 16 rising edges, sends the whole written word MSB first and returns the whole received word in the data register.
- R6: The serial clock high and low phases each last H system cycles, where H = floor((SYS_HZ + f)/(2·f)) with f = 4 096 000 >> rate code (at least 1).
- R7: With the hold flag set, the selected chip select stays low after busy falls. A later frame with the hold flag clear releases it after that frame completes. Clearing the enable releases a held chip select.
- R8: With bit 14 set, the interrupt is high for exactly one cycle, and that cycle is the first one in which busy reads 0. With bit 14 clear, no pulse occurs.
- R9: A data-register write while busy is ignored. The frame is not restarted or lengthened, the outgoing bits stay those of the first word, and the data register holds the received word, not the written one.
- R10: The serial clock is low whenever no frame is running, and it is low in any cycle where a chip select changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Byte offset: 0 control, 2 data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the devices |
| spi_miso | input | 1 | Serial data from the devices |
| spi_cs_n | output | 4 | Active-low chip selects, one per device |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest behaviours to reach from the ports are the ones between frames. One is the held chip select across a second frame. The other is a data write that lands in the middle of a running frame. Both need precise sequencing of register writes against the busy flag. The bench polls busy through the control register at every cycle. It leaves the hold flag set for a first frame and then clears it for a second frame to the same device. In a separate case, it issues a data write about twenty cycles into a slow frame. In every case, a behavioural slave counts the serial-clock edges, captures MOSI and drives known MISO words, so the bench can tell a restart or a lost bit from a correct frame.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

    localparam int unsigned WORD_W       = 16;
    localparam int unsigned ADDR_W       = 2;
    localparam int unsigned NUM_DEV      = 4;
    localparam int unsigned DEV_W        = $clog2(NUM_DEV);
    localparam int unsigned NUM_RATES    = 4;
    localparam int unsigned BASE_RATE_HZ = 4_096_000;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_DATA = 2'd2;

    typedef struct packed {
        logic             en;
        logic             ie;
        logic             hold;
        logic             wide;
        logic [DEV_W-1:0] dev;
        logic [1:0]       rate;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.en   = w[15];
        c.ie   = w[14];
        c.hold = w[11];
        c.wide = w[10];
        c.dev  = w[9:8];
        c.rate = w[1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_pack(input ctrl_t c, input logic busy);
        logic [WORD_W-1:0] w;
        w       = '0;
        w[15]   = c.en;
        w[14]   = c.ie;
        w[11]   = c.hold;
        w[10]   = c.wide;
        w[9:8]  = c.dev;
        w[7]    = busy;
        w[1:0]  = c.rate;
        return w;
    endfunction

    // nearest whole number of system cycles per serial-clock half period
    function automatic int unsigned half_cycles(input int unsigned code, input int unsigned sys_hz);
        int unsigned f;
        int unsigned h;
        f = BASE_RATE_HZ >> code;
        h = (sys_hz + f) / (2 * f);
        if (h < 1) h = 1;
        return h;
    endfunction

endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
    import spi_rm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic [WORD_W-1:0] rx_word,
    output ctrl_t             ctrl,
    output logic              start,
    output logic [WORD_W-1:0] bus_rdata
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (bus_wr && bus_addr == OFS_CTRL) begin
            ctrl_q <= ctrl_unpack(bus_wdata);
        end
    end

    assign ctrl  = ctrl_q;
    assign start = bus_wr && (bus_addr == OFS_DATA) && ctrl_q.en && !busy;

    always_comb begin
        if (bus_addr == OFS_CTRL)      bus_rdata = ctrl_pack(ctrl_q, busy);
        else if (bus_addr == OFS_DATA) bus_rdata = rx_word;
        else                           bus_rdata = '0;
    end

endmodule

// File: rtl/spi_rm_engine.sv
module spi_rm_engine
    import spi_rm_pkg::*;
#(
    parameter int unsigned SYS_HZ = 33_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  ctrl_t             ctrl,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic [WORD_W-1:0] rx_word
);

    localparam int unsigned MAX_HALF = half_cycles(NUM_RATES - 1, SYS_HZ);
    localparam int unsigned HW       = (MAX_HALF < 2) ? 1 : $clog2(MAX_HALF + 1);
    localparam int unsigned BW       = $clog2(WORD_W + 1);

    logic [HW-1:0] htab [NUM_RATES];

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        assign htab[g] = HW'(half_cycles(g, SYS_HZ));
    end

    logic              run_q, sclk_q, mosi_q, done_q, irq_q;
    logic              wide_q, ie_q;
    logic [1:0]        rate_q;
    logic [HW-1:0]     hcnt;
    logic [BW-1:0]     bitcnt;
    logic [WORD_W-1:0] sh, rx_q;
    logic [WORD_W-1:0] load_w;
    logic [BW-1:0]     nbits;
    logic              half_end;

    assign load_w   = ctrl.wide ? tx_word : {tx_word[7:0], 8'h00};
    assign nbits    = wide_q ? BW'(16) : BW'(8);
    assign half_end = (hcnt == htab[rate_q] - HW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            sclk_q <= 1'b0;
            mosi_q <= 1'b0;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
            wide_q <= 1'b0;
            ie_q   <= 1'b0;
            rate_q <= '0;
            hcnt   <= '0;
            bitcnt <= '0;
            sh     <= '0;
            rx_q   <= '0;
        end else if (!run_q) begin
            done_q <= 1'b0;
            irq_q  <= 1'b0;
            if (start) begin
                run_q  <= 1'b1;
                wide_q <= ctrl.wide;
                ie_q   <= ctrl.ie;
                rate_q <= ctrl.rate;
                sh     <= load_w;
                mosi_q <= load_w[WORD_W-1];
                hcnt   <= '0;
                bitcnt <= '0;
                sclk_q <= 1'b0;
            end
        end else if (!half_end) begin
            hcnt <= hcnt + HW'(1);
        end else begin
            hcnt <= '0;
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                sh     <= {sh[WORD_W-2:0], miso};
            end else begin
                sclk_q <= 1'b0;
                bitcnt <= bitcnt + BW'(1);
                if (bitcnt == nbits - BW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                    irq_q  <= ie_q;
                    rx_q   <= wide_q ? sh : {8'h00, sh[7:0]};
                end else begin
                    mosi_q <= sh[WORD_W-1];
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = mosi_q;
    assign busy    = run_q;
    assign done    = done_q;
    assign irq     = irq_q;
    assign rx_word = rx_q;

endmodule

// File: rtl/spi_rm_csel.sv
module spi_rm_csel
    import spi_rm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               done,
    input  logic               busy,
    input  ctrl_t              ctrl,
    output logic [NUM_DEV-1:0] cs_n
);

    logic             on_q, hold_q;
    logic [DEV_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q   <= 1'b0;
            hold_q <= 1'b0;
            sel_q  <= '0;
        end else if (start) begin
            on_q   <= 1'b1;
            hold_q <= ctrl.hold;
            sel_q  <= ctrl.dev;
        end else if (done) begin
            on_q   <= hold_q && ctrl.en;
        end else if (!ctrl.en && !busy) begin
            on_q   <= 1'b0;
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_cs
        assign cs_n[d] = !(on_q && sel_q == DEV_W'(d));
    end

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_rm_pkg::*;
#(
    parameter int unsigned SYS_HZ = 33_500_000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               spi_sclk,
    output logic               spi_mosi,
    input  logic               spi_miso,
    output logic [NUM_DEV-1:0] spi_cs_n,
    output logic               irq
);

    ctrl_t             ctrl_w;
    logic              start_w, busy_w, done_w;
    logic [WORD_W-1:0] rx_w;

    spi_rm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy_w),
        .rx_word   (rx_w),
        .ctrl      (ctrl_w),
        .start     (start_w),
        .bus_rdata (bus_rdata)
    );

    spi_rm_engine #(.SYS_HZ(SYS_HZ)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (start_w),
        .ctrl    (ctrl_w),
        .tx_word (bus_wdata),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .busy    (busy_w),
        .done    (done_w),
        .irq     (irq),
        .rx_word (rx_w)
    );

    spi_rm_csel u_csel (
        .clk   (clk),
        .rst   (rst),
        .start (start_w),
        .done  (done_w),
        .busy  (busy_w),
        .ctrl  (ctrl_w),
        .cs_n  (spi_cs_n)
    );

endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       irq,
    input logic       sclk,
    input logic       mosi,
    input logic [3:0] cs_n
);

    p_one_cs_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);

    p_cs_while_busy_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cs_n != 4'hF));

    p_sclk_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    p_sclk_low_at_cs_edge_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(cs_n) |-> !sclk);

    p_mosi_hold_high_r4: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_irq_at_busy_fall_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(busy) && !busy));

endmodule

bind spi_regmaster spi_regmaster_chk chk_i (
    .clk  (clk),
    .rst  (rst),
    .busy (busy_w),
    .irq  (irq),
    .sclk (spi_sclk),
    .mosi (spi_mosi),
    .cs_n (spi_cs_n)
);

// File: tb/spi_regmaster_tb_top.sv
`timescale 1ns/1ps
module spi_regmaster_tb_top;

    localparam int unsigned TB_SYS_HZ = 8_192_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sclk, mosi, miso, irq;
    logic [3:0]  cs_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spi_regmaster #(.SYS_HZ(TB_SYS_HZ)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(sclk),
        .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n), .irq(irq)
    );

    // behavioural slave and edge monitor
    logic [15:0] s_tx = '0;
    int          s_len = 8;
    int          s_pos = 0;
    logic [15:0] m_cap = '0;
    int          rise_cnt = 0;
    int          irq_cnt = 0;
    int          hi_w = 0, lo_w = 0;
    bit          have_fall = 0;
    time         t_r = 0, t_f = 0;

    assign miso = (s_pos < s_len) ? s_tx[s_len-1-s_pos] : 1'b0;

    always @(posedge sclk) begin
        m_cap = {m_cap[14:0], mosi};
        rise_cnt++;
        if (have_fall) lo_w = int'(($time - t_f) / 10);
        t_r = $time;
    end

    always @(negedge sclk) begin
        hi_w = int'(($time - t_r) / 10);
        t_f = $time;
        have_fall = 1;
        s_pos++;
    end

    always @(posedge clk) if (irq) irq_cnt++;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int exp_half(input int code);
        int f;
        int h;
        f = 4_096_000 >> code;
        h = (int'(TB_SYS_HZ) + f) / (2 * f);
        return (h < 1) ? 1 : h;
    endfunction

    task automatic slave_prep(input logic [15:0] w, input int len);
        s_tx = w; s_len = len; s_pos = 0;
        rise_cnt = 0; have_fall = 0; m_cap = '0; irq_cnt = 0;
    endtask

    // polls busy each cycle; returns irq value in the first idle cycle
    task automatic wait_idle(output logic irq_at_fall);
        logic [15:0] r;
        irq_at_fall = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            bus_read(2'd0, r);
            if (!r[7]) begin
                irq_at_fall = irq;
                return;
            end
        end
        check(1'b0, "R3 frame never completed", 32'd1, 32'd0);
    endtask

    task automatic t_reset;
        logic [15:0] r;
        bus_read(2'd0, r); check(r == 16'h0000, "R1 control after reset", r, 16'h0000);
        bus_read(2'd2, r); check(r == 16'h0000, "R1 data after reset", r, 16'h0000);
        check(cs_n == 4'hF, "R1 chip selects after reset", cs_n, 4'hF);
        check(sclk == 1'b0, "R1 sclk after reset", sclk, 0);
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
    endtask

    task automatic t_ctrl_readback;
        logic [15:0] r;
        bus_write(2'd0, 16'hFFFF); bus_read(2'd0, r);
        check(r == 16'hCF03, "R2 all-ones readback", r, 16'hCF03);
        bus_write(2'd0, 16'h30FC); bus_read(2'd0, r);
        check(r == 16'h0000, "R2 reserved bits read zero", r, 16'h0000);
        bus_write(2'd0, 16'h8502); bus_read(2'd0, r);
        check(r == 16'h8502, "R2 field readback", r, 16'h8502);
        bus_write(2'd0, 16'h0000);
    endtask

    task automatic t_disabled;
        logic [15:0] r;
        bit moved = 0;
        bus_write(2'd0, 16'h0100);
        bus_write(2'd2, 16'h00AA);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sclk || cs_n != 4'hF) moved = 1;
        end
        bus_read(2'd0, r);
        check(r[7] == 1'b0, "R3 disabled write leaves busy clear", r[7], 0);
        check(!moved, "R3 disabled write drives no pins", moved, 0);
    endtask

    task automatic t_byte;
        logic [15:0] r;
        logic fi;
        slave_prep(16'h003C, 8);
        bus_write(2'd0, 16'h8102);
        bus_write(2'd2, 16'h00A5);
        bus_read(2'd0, r);
        check(r[7] == 1'b1, "R3 busy after start", r[7], 1);
        check(cs_n == 4'b1101, "R3 only device 1 selected", cs_n, 4'b1101);
        wait_idle(fi);
        check(rise_cnt == 8, "R4 eight clock edges", rise_cnt, 8);
        check(m_cap[7:0] == 8'hA5, "R4 MOSI byte MSB first", m_cap[7:0], 8'hA5);
        bus_read(2'd2, r);
        check(r == 16'h003C, "R4 received byte", r, 16'h003C);
        check(hi_w == exp_half(2), "R6 high phase rate 2", hi_w, exp_half(2));
        check(lo_w == exp_half(2), "R6 low phase rate 2", lo_w, exp_half(2));
        repeat (2) @(negedge clk);
        check(cs_n == 4'hF, "R10 release without hold", cs_n, 4'hF);
        check(irq_cnt == 0, "R8 no pulse with bit 14 clear", irq_cnt, 0);
    endtask

    task automatic t_word;
        logic [15:0] r;
        logic fi;
        slave_prep(16'hBEEF, 16);
        bus_write(2'd0, 16'hC700);
        bus_write(2'd2, 16'h1234);
        check(cs_n == 4'b0111, "R3 only device 3 selected", cs_n, 4'b0111);
        wait_idle(fi);
        check(rise_cnt == 16, "R5 sixteen clock edges", rise_cnt, 16);
        check(m_cap == 16'h1234, "R5 MOSI word", m_cap, 16'h1234);
        bus_read(2'd2, r);
        check(r == 16'hBEEF, "R5 received word", r, 16'hBEEF);
        check(hi_w == exp_half(0) && lo_w == exp_half(0), "R6 phases rate 0", hi_w, exp_half(0));
        check(fi == 1'b1, "R8 pulse in first idle cycle", fi, 1);
        repeat (3) @(negedge clk);
        check(irq_cnt == 1, "R8 exactly one pulse cycle", irq_cnt, 1);
    endtask

    task automatic t_rates;
        logic fi;
        for (int c = 1; c < 4; c += 2) begin
            slave_prep(16'h0000, 8);
            bus_write(2'd0, 16'h8000 | 16'(c));
            bus_write(2'd2, 16'h0055);
            wait_idle(fi);
            check(hi_w == exp_half(c), "R6 high phase", hi_w, exp_half(c));
            check(lo_w == exp_half(c), "R6 low phase", lo_w, exp_half(c));
        end
    endtask

    task automatic t_hold;
        logic [15:0] r;
        logic fi;
        slave_prep(16'h00C3, 8);
        bus_write(2'd0, 16'h8A01);
        bus_write(2'd2, 16'h0011);
        wait_idle(fi);
        repeat (3) @(negedge clk);
        check(cs_n == 4'b1011, "R7 held after first frame", cs_n, 4'b1011);
        slave_prep(16'h0096, 8);
        bus_write(2'd0, 16'h8201);
        check(cs_n == 4'b1011, "R7 still held before second frame", cs_n, 4'b1011);
        bus_write(2'd2, 16'h0022);
        wait_idle(fi);
        bus_read(2'd2, r);
        check(r == 16'h0096, "R7 second frame data", r, 16'h0096);
        repeat (2) @(negedge clk);
        check(cs_n == 4'hF, "R7 released after last frame", cs_n, 4'hF);
        slave_prep(16'h0000, 8);
        bus_write(2'd0, 16'h8A01);
        bus_write(2'd2, 16'h0033);
        wait_idle(fi);
        repeat (2) @(negedge clk);
        check(cs_n == 4'b1011, "R7 held again", cs_n, 4'b1011);
        bus_write(2'd0, 16'h0000);
        repeat (2) @(negedge clk);
        check(cs_n == 4'hF, "R7 disable releases hold", cs_n, 4'hF);
    endtask

    task automatic t_busy_write;
        logic [15:0] r;
        logic fi;
        slave_prep(16'h005A, 8);
        bus_write(2'd0, 16'h8003);
        bus_write(2'd2, 16'h0081);
        repeat (20) @(negedge clk);
        bus_write(2'd2, 16'h00FF);
        wait_idle(fi);
        check(rise_cnt == 8, "R9 frame not restarted", rise_cnt, 8);
        check(m_cap[7:0] == 8'h81, "R9 first word sent", m_cap[7:0], 8'h81);
        bus_read(2'd2, r);
        check(r == 16'h005A, "R9 data holds received word", r, 16'h005A);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, run hung");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl_readback();
        t_disabled();
        t_byte();
        t_word();
        t_rates();
        t_hold();
        t_busy_write();
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule